// File: doc/BRIEF.md
# Cartridge Bank Select Controller

This block maps a banked cartridge of up to 128 banks of 8 kB onto a fixed 8 kB read window of the host CPU. The banks are split across two 512 kB memory chips. The CPU picks a bank by writing anywhere in the cartridge I/O page. The bank number is taken from the low bits of the write address, and the data byte plays no part. One I/O offset turns the cartridge off. Any later bank selection turns it back on.

The host decodes its own address map. It gives the block one select for the I/O page and one select for the memory window, plus the low 13 address bits and a write strobe. The block returns the chip-side address and one enable per chip. It also returns a write enable, held back for the boot chip while the write-protect input is high, and a window-enable flag that tells the host the cartridge is present.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the bank is 0 and the cartridge is on: `win_en` is 1 and `mem_addr[18:13]` is 0.
- R2: A write strobe with `io_sel` high and `cpu_addr[7]` = 0 selects bank `cpu_addr[6:0]`. From the next clock on, `mem_addr[18:13]` shows bank bits [5:0].
- R3: A write strobe with `io_sel` high and `cpu_addr[7:0]` = 0x80 turns the cartridge off from the next clock on. While it is off, `win_en`, both bits of `chip_en` and `mem_we` are 0.
- R4: While the cartridge is off, an I/O write to an offset in 0x00–0x7F turns it back on and selects that bank.
- R5: I/O writes to offsets 0x81–0xFF leave both the bank and the on/off state unchanged.
- R6: Bank bit 6 picks the chip. `chip_en[0]` covers banks 0x00–0x3F and `chip_en[1]` covers banks 0x40–0x7F. A chip enable is high only while `win_sel` is high and the cartridge is on. The unselected chip's enable stays 0.
- R7: `mem_addr` is {bank[5:0], `cpu_addr[12:0]`}, following the address in the same cycle.
- R8: While `wp` is high, `mem_we` stays 0 for chip 0. Chip 1 is writable whatever `wp` is.
- R9: `mem_we` is high only in a cycle where `cpu_we` and `win_sel` are both high and the cartridge is on.
- R10: Cycles without both `io_sel` and `cpu_we` do not change the bank or the on/off state. This includes window writes whose low address byte equals an I/O command offset.
- R11: Only `cpu_addr[7:0]` is decoded for I/O writes. `cpu_addr[12:8]` has no effect on the bank selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_sel | input | 1 | Cartridge I/O page is addressed |
| win_sel | input | 1 | Memory window is addressed |
| cpu_we | input | 1 | CPU write strobe for this bus cycle |
| cpu_addr | input | 13 | Low CPU address bits |
| wp | input | 1 | Write protect for chip 0 |
| mem_addr | output | 19 | Address presented to both chips |
| chip_en | output | 2 | Per-chip enable, active high |
| mem_we | output | 1 | Memory write enable, active high |
| win_en | output | 1 | Cartridge present in the window |

## Verification
Only two pieces of state exist: the bank register and the on/off flag. A fault in either shows at the ports in the first window access that follows. A wrong bank moves `mem_addr[18:13]`, or moves the chip enable to the other chip. A wrong on/off flag shows at once on `win_en`. The risky moments are the I/O writes at the edges of the decode: offsets 0x7F, 0x80 and 0x81, and offsets with high address bits set. Writes to the boot chip under write protect are a second risk, because a wrong gate shows as a stray `mem_we` in that same cycle. Each of these is followed by a window access in the very next cycle, so a fault shows within one clock.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    // Bits of bank number inside one chip, chip-select bits, window offset bits
    parameter int unsigned CHIP_BANK_BITS = 6;
    parameter int unsigned CHIP_SEL_BITS  = 1;
    parameter int unsigned WIN_ADDR_BITS  = 13;

    // Command decoded from an I/O page write
    typedef enum logic [1:0] {
        IO_NONE   = 2'd0,
        IO_SELECT = 2'd1,
        IO_OFF    = 2'd2
    } io_cmd_e;

endpackage

// File: rtl/cart_io_decode.sv
module cart_io_decode
    import cart_bank_pkg::*;
#(
    parameter int unsigned BANK_W = 7,
    parameter int unsigned OFS_W  = BANK_W + 1
) (
    input  logic              io_sel,
    input  logic              cpu_we,
    input  logic [OFS_W-1:0]  offset,
    output io_cmd_e           cmd,
    output logic [BANK_W-1:0] new_bank
);

    // Bank number comes from the address; the top offset bit marks commands
    assign new_bank = offset[BANK_W-1:0];

    always_comb begin
        cmd = IO_NONE;
        if (io_sel && cpu_we) begin
            if (!offset[OFS_W-1]) begin
                cmd = IO_SELECT;
            end else if (offset[BANK_W-1:0] == '0) begin
                cmd = IO_OFF;
            end
        end
    end

endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg
    import cart_bank_pkg::*;
#(
    parameter int unsigned BANK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  io_cmd_e           cmd,
    input  logic [BANK_W-1:0] new_bank,
    output logic [BANK_W-1:0] bank,
    output logic              cart_on
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              on;
    } bank_state_t;

    bank_state_t st_d;
    bank_state_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            IO_SELECT: begin
                st_d.bank = new_bank;
                st_d.on   = 1'b1;
            end
            IO_OFF: begin
                st_d.on   = 1'b0;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bank <= '0;
            st_q.on   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank    = st_q.bank;
    assign cart_on = st_q.on;

endmodule

// File: rtl/cart_mem_route.sv
module cart_mem_route
    import cart_bank_pkg::*;
#(
    parameter int unsigned BANK_W    = 7,
    parameter int unsigned CBB       = 6,
    parameter int unsigned CSB       = 1,
    parameter int unsigned WAB       = 13,
    parameter int unsigned NUM_CHIPS = 1 << CSB,
    parameter int unsigned MA_W      = CBB + WAB
) (
    input  logic                 cart_on,
    input  logic [BANK_W-1:0]    bank,
    input  logic                 win_sel,
    input  logic                 cpu_we,
    input  logic                 wp,
    input  logic [WAB-1:0]       cpu_addr,
    output logic [MA_W-1:0]      mem_addr,
    output logic [NUM_CHIPS-1:0] chip_en,
    output logic                 mem_we,
    output logic                 win_en
);

    logic [CSB-1:0]       chip_sel;
    logic [NUM_CHIPS-1:0] writable;

    assign chip_sel = bank[BANK_W-1 -: CSB];
    assign mem_addr = {bank[CBB-1:0], cpu_addr};
    assign win_en   = cart_on;

    for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_chip
        assign chip_en[i] = cart_on && win_sel && (chip_sel == CSB'(i));
        if (i == 0) begin : g_boot
            assign writable[i] = !wp;
        end else begin : g_free
            assign writable[i] = 1'b1;
        end
    end

    assign mem_we = cpu_we && |(chip_en & writable);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int unsigned CBB = CHIP_BANK_BITS,
    parameter int unsigned CSB = CHIP_SEL_BITS,
    parameter int unsigned WAB = WIN_ADDR_BITS,
    localparam int unsigned BANK_W    = CBB + CSB,
    localparam int unsigned OFS_W     = BANK_W + 1,
    localparam int unsigned NUM_CHIPS = 1 << CSB,
    localparam int unsigned MA_W      = CBB + WAB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_sel,
    input  logic                 win_sel,
    input  logic                 cpu_we,
    input  logic [WAB-1:0]       cpu_addr,
    input  logic                 wp,
    output logic [MA_W-1:0]      mem_addr,
    output logic [NUM_CHIPS-1:0] chip_en,
    output logic                 mem_we,
    output logic                 win_en
);

    io_cmd_e           cmd;
    logic [BANK_W-1:0] new_bank;
    logic [BANK_W-1:0] bank;
    logic              cart_on;

    cart_io_decode #(
        .BANK_W (BANK_W),
        .OFS_W  (OFS_W)
    ) i_decode (
        .io_sel   (io_sel),
        .cpu_we   (cpu_we),
        .offset   (cpu_addr[OFS_W-1:0]),
        .cmd      (cmd),
        .new_bank (new_bank)
    );

    cart_bank_reg #(
        .BANK_W (BANK_W)
    ) i_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .new_bank (new_bank),
        .bank     (bank),
        .cart_on  (cart_on)
    );

    cart_mem_route #(
        .BANK_W    (BANK_W),
        .CBB       (CBB),
        .CSB       (CSB),
        .WAB       (WAB),
        .NUM_CHIPS (NUM_CHIPS),
        .MA_W      (MA_W)
    ) i_route (
        .cart_on  (cart_on),
        .bank     (bank),
        .win_sel  (win_sel),
        .cpu_we   (cpu_we),
        .wp       (wp),
        .cpu_addr (cpu_addr),
        .mem_addr (mem_addr),
        .chip_en  (chip_en),
        .mem_we   (mem_we),
        .win_en   (win_en)
    );

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
    parameter int unsigned CBB       = 6,
    parameter int unsigned WAB       = 13,
    parameter int unsigned BANK_W    = 7,
    parameter int unsigned NUM_CHIPS = 2,
    parameter int unsigned MA_W      = 19
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 io_sel,
    input logic                 win_sel,
    input logic                 cpu_we,
    input logic [WAB-1:0]       cpu_addr,
    input logic                 wp,
    input logic [BANK_W-1:0]    bank,
    input logic                 cart_on,
    input logic [MA_W-1:0]      mem_addr,
    input logic [NUM_CHIPS-1:0] chip_en,
    input logic                 mem_we,
    input logic                 win_en
);

    logic io_wr;
    assign io_wr = io_sel && cpu_we;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (win_en && mem_addr[MA_W-1 -: CBB] == '0));

    p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !cpu_addr[BANK_W]) |=>
            (bank == $past(cpu_addr[BANK_W-1:0]) && win_en));

    p_turn_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && cpu_addr[BANK_W:0] == {1'b1, {BANK_W{1'b0}}}) |=> !win_en);

    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> (chip_en == '0 && !mem_we));

    p_ignore_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && cpu_addr[BANK_W] && cpu_addr[BANK_W-1:0] != '0) |=>
            ($stable(bank) && $stable(cart_on)));

    p_one_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_en));

    p_chip_needs_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en != '0) |-> win_sel);

    p_addr_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[WAB-1:0] == cpu_addr);

    p_wp_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wp && mem_we) |-> !chip_en[0]);

    p_we_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cpu_we && win_sel && win_en));

    p_no_io_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> ($stable(bank) && $stable(cart_on)));

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
    .CBB       (CBB),
    .WAB       (WAB),
    .BANK_W    (BANK_W),
    .NUM_CHIPS (NUM_CHIPS),
    .MA_W      (MA_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_sel   (io_sel),
    .win_sel  (win_sel),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .wp       (wp),
    .bank     (bank),
    .cart_on  (cart_on),
    .mem_addr (mem_addr),
    .chip_en  (chip_en),
    .mem_we   (mem_we),
    .win_en   (win_en)
);

// File: tb/test_cart_bank_ctrl.sv
`timescale 1ns/1ps
module test_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0;
    logic        win_sel = 1'b0;
    logic        cpu_we = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic        wp = 1'b0;
    logic [18:0] mem_addr;
    logic [1:0]  chip_en;
    logic        mem_we;
    logic        win_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cart_bank_ctrl i_cart_bank_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_sel   (io_sel),
        .win_sel  (win_sel),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .wp       (wp),
        .mem_addr (mem_addr),
        .chip_en  (chip_en),
        .mem_we   (mem_we),
        .win_en   (win_en)
    );

    typedef struct {
        string       req;
        logic        win_en;
        logic [1:0]  chip_en;
        logic [18:0] mem_addr;
        logic        mem_we;
    } exp_t;

    exp_t sb[$];

    // Bench reference state, built from the requirements
    logic [6:0] m_bank = '0;
    bit         m_on = 1'b1;

    task automatic step(input string req, input bit io, input bit win,
                        input bit we, input bit wpi, input logic [12:0] a);
        exp_t e;
        @(negedge clk);
        io_sel = io; win_sel = win; cpu_we = we; wp = wpi; cpu_addr = a;
        e.req      = req;
        e.win_en   = m_on;
        e.chip_en  = (m_on && win) ? (m_bank[6] ? 2'b10 : 2'b01) : 2'b00;
        e.mem_addr = {m_bank[5:0], a};
        e.mem_we   = we && win && m_on && !(wpi && !m_bank[6]);
        sb.push_back(e);
        if (io && we) begin
            if (!a[7]) begin
                m_bank = a[6:0];
                m_on   = 1'b1;
            end else if (a[6:0] == 7'h00) begin
                m_on   = 1'b0;
            end
        end
    endtask

    // Monitor: compare outputs mid-cycle against queued expectations
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (win_en !== e.win_en || chip_en !== e.chip_en ||
                    mem_addr !== e.mem_addr || mem_we !== e.mem_we) begin
                    errors++;
                    $display("FAIL %s: got win_en=%b chip_en=%b mem_addr=%h mem_we=%b, expected win_en=%b chip_en=%b mem_addr=%h mem_we=%b",
                             e.req, win_en, chip_en, mem_addr, mem_we,
                             e.win_en, e.chip_en, e.mem_addr, e.mem_we);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step("R1", 0, 0, 0, 0, 13'h0000);
        // R7: address passes through, bank 0 on chip 0
        step("R7", 0, 1, 0, 0, 13'h1ABC);
        // R2: select bank 5, then read the window
        step("R2", 1, 0, 1, 0, 13'h0005);
        step("R2", 0, 1, 0, 0, 13'h0123);
        // R6: bank 0x45 is on chip 1
        step("R6", 1, 0, 1, 0, 13'h0045);
        step("R6", 0, 1, 0, 0, 13'h0FFF);
        // R8: chip 1 writable under write protect
        step("R8", 0, 1, 1, 1, 13'h0010);
        // R8: chip 0 blocked under write protect, then writable without it
        step("R8", 1, 0, 1, 0, 13'h003F);
        step("R8", 0, 1, 1, 1, 13'h0020);
        step("R9", 0, 1, 1, 0, 13'h0020);
        // R9: no write strobe, no write enable
        step("R9", 0, 1, 0, 0, 13'h0021);
        // R5: offsets 0x81..0xFF ignored
        step("R5", 1, 0, 1, 0, 13'h009A);
        step("R5", 0, 1, 0, 0, 13'h0001);
        step("R5", 1, 0, 1, 0, 13'h00FF);
        step("R5", 0, 1, 0, 0, 13'h0002);
        step("R5", 1, 0, 1, 0, 13'h0081);
        step("R5", 0, 1, 0, 0, 13'h0003);
        // R10: window write at 0x80 and unstrobed I/O access change nothing
        step("R10", 0, 1, 1, 0, 13'h0080);
        step("R10", 1, 0, 0, 0, 13'h0080);
        step("R10", 1, 0, 0, 0, 13'h0011);
        step("R10", 0, 1, 0, 0, 13'h0004);
        // R3: turn off, window access is quiet
        step("R3", 1, 0, 1, 0, 13'h0080);
        step("R3", 0, 1, 1, 0, 13'h0005);
        step("R3", 0, 1, 0, 0, 13'h0006);
        // R5: ignored offset while off keeps it off
        step("R5", 1, 0, 1, 0, 13'h0085);
        step("R5", 0, 1, 0, 0, 13'h0007);
        // R4: bank 0x7F turns it back on, chip 1
        step("R4", 1, 0, 1, 0, 13'h007F);
        step("R4", 0, 1, 1, 1, 13'h1234);
        // R11: high address bits ignored in I/O decode
        step("R11", 1, 0, 1, 0, 13'h1F05);
        step("R11", 0, 1, 0, 0, 13'h0008);
        step("R11", 1, 0, 1, 0, 13'h1E80);
        step("R11", 0, 1, 0, 0, 13'h0009);
        step("R11", 1, 0, 1, 0, 13'h0300);
        step("R11", 0, 1, 0, 0, 13'h000A);
        step("R7", 0, 0, 0, 0, 13'h0000);
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule